// File: doc/BRIEF.md
# Clamped Digital PI Regulator

This block closes a sampled control loop in the digital domain. Each time a new 10-bit measurement arrives with a valid strobe, it forms the error against a programmed target. It then builds an output code from three parts: a programmable centre level, a proportional term and an integral term. The sum is limited to a programmable window. An external comparator fault line overrides the regulated value with a programmed safe code, so a downstream converter can be driven to a known level when something goes wrong.

Configuration arrives through a one-cycle write port. Address 0 holds the run bit. The target and the centre level can be retuned while the loop runs. All other settings are taken only while the loop is stopped. Stopping the loop also empties the integrator, so every restart begins from the centre level.

Top module: `pi_regulator`

## Requirements
- R1: After reset, out_code is 0, out_valid is 0 and the loop is stopped. The settings reset to: target 512, centre level 767, proportional gain 100, integral divisor 0, upper bound 1023, lower bound 0, normal polarity, safe code 0.
- R2: Settings are written with cfg_we high for one cycle. cfg_addr selects the setting and the low bits of cfg_wdata carry the value. Addr 1 is the 10-bit target, addr 2 the 10-bit centre level, addr 3 the 16-bit proportional gain, addr 4 the 16-bit integral divisor, addr 5 the upper bound, addr 6 the lower bound, addr 7 the safe code and addr 8 bit 0 the polarity. The error is the target minus the sample. The proportional term is (gain × error) shifted right arithmetically by 8. The unclamped output is the centre level plus the proportional term plus the integral term.
- R3: A strobe sampled on clock edge k produces out_valid high for exactly one cycle, and a new out_code, both after edge k+1.
- R4: With the polarity setting at 1, the sign of the error is inverted before it is used.
- R5: The integrator adds the current error to its stored value. The integral term is that new sum divided by the integral divisor, truncated toward zero. A divisor of 0 makes the integral term 0.
- R6: The sum is first limited to the upper bound and then raised to the lower bound. If the lower bound exceeds the upper bound, the lower bound is the result.
- R7: The integrator keeps its old value for any sample whose sum was limited by either bound, and for any sample taken with the fault line high.
- R8: A sample strobed while cmp_trip is high produces the safe code on out_code, whatever the regulated value would have been.
- R9: The integrator is a signed register of ACC_W bits (32 by default) that saturates at its most positive and most negative values instead of wrapping.
- R10: Address 0 bit 0 is the run bit. While it is 0, strobes produce no out_valid and out_code holds its value. Clearing it empties the integrator.
- R11: Writes to addresses 1 and 2 take effect at any time. Writes to addresses 3 to 8 are ignored while the run bit is 1. A target write issued in the same cycle as a strobe does not affect that sample; the sample uses the old target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_addr | input | 4 | Setting select |
| cfg_wdata | input | 16 | Setting value |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | 10 | Sensed sample |
| cmp_trip | input | 1 | Comparator fault, sampled with the strobe |
| out_code | output | 10 | Output code |
| out_valid | output | 1 | One-cycle pulse marking a new output |

## Verification
Two collisions in a single sample need care. In the first, a fault coincides with an error large enough to drive the sum past a bound. The bench strobes such a sample with cmp_trip high and expects the safe code. It also expects the integrator to be untouched, which shows up in the next untripped output. In the second, a live target write lands in the same cycle as a strobe. The bench drives both on one edge, expects that sample to use the old target, and expects the next sample to use the new one.

// File: rtl/pi_regulator.sv
`timescale 1ns/1ps
module pi_regulator #(
  parameter int DW     = 10,
  parameter int GW     = 16,
  parameter int AW     = 4,
  parameter int ACC_W  = 32,
  parameter int PSHIFT = 8,
  parameter int KP_RST = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [GW-1:0] cfg_wdata,
  input  logic          smp_vld,
  input  logic [DW-1:0] smp_data,
  input  logic          cmp_trip,
  output logic [DW-1:0] out_code,
  output logic          out_valid
);
  localparam int EW  = DW + 1;
  localparam int PW  = EW + GW + 1;
  localparam int MW  = (ACC_W > PW) ? ACC_W : PW;
  localparam int ID  = ((ACC_W > GW) ? ACC_W : GW) + 1;
  localparam int SW  = MW + 3;
  localparam logic [DW-1:0] SP_RST = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] CM_RST = {2'b10, {(DW-2){1'b1}}};
  localparam logic signed [ACC_W-1:0] A_HI = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] A_LO = {1'b1, {(ACC_W-1){1'b0}}};

  logic          run_q, pol_q;
  logic [DW-1:0] sp_q, cm_q, hi_q, lo_q, safe_q;
  logic [GW-1:0] kp_q, ki_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;  pol_q <= 1'b0;
      sp_q  <= SP_RST; cm_q <= CM_RST;
      kp_q  <= GW'(KP_RST); ki_q <= '0;
      hi_q  <= '1;    lo_q <= '0;  safe_q <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        AW'(0): run_q <= cfg_wdata[0];
        AW'(1): sp_q  <= cfg_wdata[DW-1:0];
        AW'(2): cm_q  <= cfg_wdata[DW-1:0];
        default:
          if (!run_q) begin
            case (cfg_addr)
              AW'(3): kp_q   <= cfg_wdata;
              AW'(4): ki_q   <= cfg_wdata;
              AW'(5): hi_q   <= cfg_wdata[DW-1:0];
              AW'(6): lo_q   <= cfg_wdata[DW-1:0];
              AW'(7): safe_q <= cfg_wdata[DW-1:0];
              AW'(8): pol_q  <= cfg_wdata[0];
              default: ;
            endcase
          end
      endcase
    end
  end

  // stage 1: signed error and fault capture
  logic signed [EW-1:0] e_raw, e_q;
  logic                 s1_vld, s1_trip;
  assign e_raw = $signed({1'b0, sp_q}) - $signed({1'b0, smp_data});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld <= 1'b0; s1_trip <= 1'b0; e_q <= '0;
    end else begin
      s1_vld <= run_q & smp_vld;
      if (smp_vld) begin
        e_q     <= pol_q ? -e_raw : e_raw;
        s1_trip <= cmp_trip;
      end
    end
  end

  // stage 2 datapath
  logic signed [PW-1:0]    err_x, kp_x, prod, p_term;
  logic signed [ACC_W:0]   acc_wide;
  logic signed [ACC_W-1:0] acc_q, acc_nx;
  logic signed [ID-1:0]    num, den, quo;
  logic [GW-1:0]           ki_safe;
  logic signed [SW-1:0]    i_ext, p_ext, cm_ext, hi_ext, lo_ext, sum, v1;
  logic                    over, under;
  logic [DW-1:0]           lim;

  assign err_x  = {{(PW-EW){e_q[EW-1]}}, e_q};
  assign kp_x   = {{(PW-GW){1'b0}}, kp_q};
  assign prod   = err_x * kp_x;
  assign p_term = prod >>> PSHIFT;

  assign acc_wide = {acc_q[ACC_W-1], acc_q} + {{(ACC_W+1-EW){e_q[EW-1]}}, e_q};
  assign acc_nx   = (acc_wide[ACC_W] == acc_wide[ACC_W-1]) ? acc_wide[ACC_W-1:0]
                  : (acc_wide[ACC_W] ? A_LO : A_HI);

  assign ki_safe = (ki_q == '0) ? GW'(1) : ki_q;
  assign num     = {{(ID-ACC_W){acc_nx[ACC_W-1]}}, acc_nx};
  assign den     = {{(ID-GW){1'b0}}, ki_safe};
  assign quo     = num / den;

  assign i_ext  = (ki_q == '0) ? '0 : {{(SW-ID){quo[ID-1]}}, quo};
  assign p_ext  = {{(SW-PW){p_term[PW-1]}}, p_term};
  assign cm_ext = {{(SW-DW){1'b0}}, cm_q};
  assign hi_ext = {{(SW-DW){1'b0}}, hi_q};
  assign lo_ext = {{(SW-DW){1'b0}}, lo_q};
  assign sum    = cm_ext + p_ext + i_ext;
  assign over   = sum > hi_ext;
  assign v1     = over ? hi_ext : sum;
  assign under  = v1 < lo_ext;
  assign lim    = under ? lo_q : v1[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_code <= '0; out_valid <= 1'b0; acc_q <= '0;
    end else begin
      out_valid <= s1_vld & run_q;
      if (!run_q) begin
        acc_q <= '0;
      end else if (s1_vld) begin
        out_code <= s1_trip ? safe_q : lim;
        if (!s1_trip && !over && !under) acc_q <= acc_nx;
      end
    end
  end

  assert_valid_pipe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(s1_vld));
  assert_stage1_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |-> $past(smp_vld));
  assert_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(s1_trip) && hi_q >= lo_q) |-> (out_code <= hi_q && out_code >= lo_q));
  assert_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(s1_trip)) |-> out_code >= lo_q);
  assert_trip_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(s1_trip)) |-> acc_q == $past(acc_q));
  assert_safe_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(s1_trip)) |-> out_code == safe_q);
  assert_stop_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (acc_q == '0 && !out_valid));
endmodule

// File: tb/pi_regulator_tb.sv
`timescale 1ns/1ps
module pi_regulator_tb_top;
  localparam int ACCW = 14;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic smp_vld = 1'b0, cmp_trip = 1'b0;
  logic [9:0] smp_data = '0;
  logic [9:0] out_code;
  logic out_valid;

  always #10 clk = ~clk;

  pi_regulator #(.ACC_W(ACCW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .smp_vld(smp_vld), .smp_data(smp_data),
    .cmp_trip(cmp_trip), .out_code(out_code), .out_valid(out_valid));

  int total = 0, bad = 0;
  longint m_sp = 512, m_cm = 767, m_kp = 100, m_ki = 0, m_hi = 1023, m_lo = 0, m_safe = 0;
  longint m_acc = 0;
  bit m_pol = 0, m_run = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = 16'(data);
    case (addr)
      0: begin m_run = data[0]; if (!m_run) m_acc = 0; end
      1: m_sp = data;
      2: m_cm = data;
      default: if (!m_run) case (addr)
        3: m_kp = data; 4: m_ki = data; 5: m_hi = data;
        6: m_lo = data; 7: m_safe = data; 8: m_pol = data[0];
        default: ;
      endcase
    endcase
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic longint predict(input longint smp, input bit trip);
    longint e, p, an, i, s, v;
    e = m_sp - smp;
    if (m_pol) e = -e;
    p = (m_kp * e) >>> 8;
    an = m_acc + e;
    if (an > (64'sd1 << (ACCW-1)) - 1) an = (64'sd1 << (ACCW-1)) - 1;
    if (an < -(64'sd1 << (ACCW-1))) an = -(64'sd1 << (ACCW-1));
    i = (m_ki == 0) ? 0 : an / m_ki;
    s = m_cm + p + i;
    v = (s > m_hi) ? m_hi : s;
    v = (v < m_lo) ? m_lo : v;
    if (trip) return m_safe;
    if (v == s) m_acc = an;
    return v;
  endfunction

  task automatic do_sample(input int smp, input bit trip, input string req);
    longint exp;
    exp = predict(smp, trip);
    @(negedge clk);
    smp_vld = 1'b1; smp_data = 10'(smp); cmp_trip = trip;
    @(negedge clk);
    smp_vld = 1'b0; cmp_trip = 1'b0;
    @(negedge clk);
    chk({req, " R3 valid"}, out_valid, 1);
    chk(req, out_code, exp);
    @(negedge clk);
    chk("R3 pulse width", out_valid, 0);
  endtask

  task automatic t_reset();
    chk("R1 out_code", out_code, 0);
    chk("R1 out_valid", out_valid, 0);
    @(negedge clk);
    smp_vld = 1'b1; smp_data = 10'd100;
    @(negedge clk);
    smp_vld = 1'b0;
    @(negedge clk);
    chk("R10 stopped valid", out_valid, 0);
    @(negedge clk);
    chk("R10 stopped hold", out_code, 0);
  endtask

  task automatic t_defaults();
    wr(0, 1);
    do_sample(512, 0, "R1 centre");
    do_sample(400, 0, "R1 default gain");
    do_sample(700, 0, "R2 negative error");
    do_sample(400, 0, "R5 divisor zero");
  endtask

  task automatic t_prop();
    wr(0, 0); wr(3, 256); wr(2, 500); wr(0, 1);
    do_sample(100, 0, "R2 gain one high");
    do_sample(900, 0, "R2 gain one low");
    do_sample(512, 0, "R2 zero error");
  endtask

  task automatic t_pol();
    wr(0, 0); wr(8, 1); wr(0, 1);
    do_sample(600, 0, "R4 inverted up");
    do_sample(400, 0, "R4 inverted down");
    wr(0, 0); wr(8, 0);
  endtask

  task automatic t_integral();
    wr(3, 0); wr(4, 4); wr(0, 1);
    do_sample(500, 0, "R5 step1");
    do_sample(500, 0, "R5 step2");
    do_sample(530, 0, "R5 step3");
    do_sample(560, 0, "R5 negative trunc");
  endtask

  task automatic t_clamp();
    wr(0, 0); wr(4, 0); wr(3, 1024); wr(5, 600); wr(6, 300); wr(0, 1);
    do_sample(400, 0, "R6 upper");
    do_sample(700, 0, "R6 lower");
    do_sample(500, 0, "R6 inside");
    wr(0, 0); wr(6, 700); wr(0, 1);
    do_sample(512, 0, "R6 lower wins");
  endtask

  task automatic t_windup();
    wr(0, 0); wr(5, 520); wr(6, 0); wr(3, 0); wr(4, 2); wr(0, 1);
    do_sample(492, 0, "R7 a");
    do_sample(492, 0, "R7 b");
    do_sample(492, 0, "R7 clamped");
    do_sample(522, 0, "R7 no windup");
  endtask

  task automatic t_trip();
    wr(0, 0); wr(7, 77); wr(0, 1);
    do_sample(492, 0, "R8 before");
    do_sample(452, 1, "R8 safe code");
    do_sample(492, 0, "R7 trip froze integrator");
    do_sample(300, 1, "R8 trip with clamp");
    do_sample(512, 0, "R7 after trip clamp");
  endtask

  task automatic t_sat();
    wr(0, 0); wr(4, 16); wr(5, 1023); wr(2, 300); wr(1, 1023); wr(0, 1);
    for (int n = 0; n < 10; n++) do_sample(0, 0, "R9 ramp");
    wr(1, 0);
    do_sample(1023, 0, "R9 saturated");
  endtask

  task automatic t_live();
    longint exp;
    wr(3, 256);
    wr(1, 500);
    do_sample(400, 0, "R11 gain ignored while running");
    wr(2, 200);
    do_sample(500, 0, "R11 live centre");
    exp = predict(500, 0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd1; cfg_wdata = 16'd600;
    smp_vld = 1'b1; smp_data = 10'd500;
    @(negedge clk);
    cfg_we = 1'b0; smp_vld = 1'b0;
    m_sp = 600;
    @(negedge clk);
    chk("R11 same-cycle valid", out_valid, 1);
    chk("R11 same-cycle old target", out_code, exp);
    do_sample(500, 0, "R11 new target");
  endtask

  task automatic t_stop();
    wr(0, 0);
    wr(0, 1);
    do_sample(600, 0, "R10 integrator emptied");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_defaults();
    t_prop();
    t_pol();
    t_integral();
    t_clamp();
    t_windup();
    t_trip();
    t_sat();
    t_live();
    t_stop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R3 watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule